// File: doc/BRIEF.md
# Short-Range Packet Framer and Address Filter

This block sits between a game or application layer and the byte-wide FIFO port of a 2.4 GHz packet radio. On the send side it accepts one 32-bit payload word together with a destination address. It then emits a fixed frame one byte at a time toward the radio's transmit FIFO writer. The frame opens with a length byte and closes with two zero bytes, which the radio replaces with its own checksum. Preamble and start-of-frame delimiter are added by the radio and never pass through this block.

On the receive side it consumes bytes read out of the radio's receive FIFO and parses them into frames. A frame is kept only if it is addressed to one of the node's two local addresses or to broadcast, and its payload word is then handed on with the sender's address. Frames of any other length are drained and thrown away, so foreign traffic cannot wedge the parser. A 4-bit channel register can be rewritten at any time. A pending flag tells the radio configuration logic that a new channel must be applied, and it stays set until that logic acknowledges.

Every word and byte port uses a ready/start handshake. A transfer happens in a cycle where the receiving side's ready and the sending side's start are both high.

Top module: `pkt_framer`

## Requirements
- R1: After reset, and whenever no frame is being sent, `tx_word_ready` is 1. A word is taken in a cycle where `tx_word_start` and `tx_word_ready` are both 1. `tx_word_ready` then stays 0 until the last byte of that frame has been transferred, and any `tx_word_start` in that time is ignored.
- R2: The transmit byte order is fixed. It is the length value 8, then `tx_dst`, then `addr_a` as the source, then the four payload bytes with bit 31..24 first, then two 0x00 bytes. Nine bytes are sent in all.
- R3: While `txb_start` is 1 and `txb_ready` is 0, `txb_start` stays 1 and `txb_data` holds its value.
- R4: A received frame is a length byte of 8, then destination, source, four payload bytes (most significant first) and two checksum bytes whose value is ignored. If the destination equals `addr_a` or `addr_b`, the frame is delivered on `rx_word` with `rx_src` in the cycle after its last byte is taken.
- R5: A received frame with destination 0xFF is delivered as broadcast whatever the local addresses are.
- R6: A received frame whose destination matches neither local address and is not 0xFF is dropped without output. A destination of 0x00 is always dropped.
- R7: A length byte other than 8 and 0 causes exactly that many following bytes to be consumed and discarded. A length byte of 0 is consumed alone. In both cases the next byte is treated as a new length byte.
- R8: A delivered word keeps `rx_word_start` high with `rx_word` and `rx_src` unchanged until `rx_word_ready` is 1. Meanwhile `rxb_ready` is 0.
- R9: A `ch_req_start` pulse loads `ch_req_val` into `chan` on the next cycle and sets `ch_pending`. `ch_ack` clears `ch_pending`. If a request and an acknowledge arrive in the same cycle, the request wins.
- R10: After reset `chan` is 0, `ch_pending` is 0, `txb_start` is 0, `rx_word_start` is 0 and `rxb_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_a | input | 8 | First local address, also used as transmit source |
| addr_b | input | 8 | Second local address |
| tx_word_start | input | 1 | Offer a payload word for sending |
| tx_word | input | 32 | Payload word to send |
| tx_dst | input | 8 | Destination address for the word |
| tx_word_ready | output | 1 | Framer can take a word |
| txb_start | output | 1 | Frame byte available toward transmit FIFO |
| txb_data | output | 8 | Frame byte |
| txb_ready | input | 1 | Transmit FIFO writer can take a byte |
| rxb_start | input | 1 | Byte available from receive FIFO |
| rxb_data | input | 8 | Received byte |
| rxb_ready | output | 1 | Parser can take a byte |
| rx_word_start | output | 1 | Accepted payload word available |
| rx_word | output | 32 | Accepted payload word |
| rx_src | output | 8 | Source address of the accepted frame |
| rx_word_ready | input | 1 | Consumer takes the delivered word |
| ch_req_start | input | 1 | Request a channel change |
| ch_req_val | input | 4 | Requested channel |
| chan | output | 4 | Current channel |
| ch_pending | output | 1 | Channel change not yet acknowledged |
| ch_ack | input | 1 | Configuration logic applied the channel |

## Verification
A word taken at clock edge k puts the length byte on `txb_data` just after k. With `txb_ready` held high, byte i is transferred at edge k+1+i and `tx_word_ready` returns one cycle after the ninth byte. A frame's last received byte taken at edge j raises `rx_word_start` just after j. A channel request at edge m is visible on `chan` and `ch_pending` just after m. The bench drives every input at the falling edge and reads every output at the next falling edge, so each check samples the half cycle after the edge that is due to produce the result, and a stall test holds `txb_ready` low across two falling edges to see the byte hold.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int ADDR_W    = 8;
  localparam int PAY_BYTES = 4;
  localparam int CRC_BYTES = 2;
  localparam int CH_W      = 4;
  localparam logic [ADDR_W-1:0] ADDR_NONE  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_BCAST = 8'hFF;

  typedef enum logic [1:0] {
    RXS_LEN   = 2'd0,
    RXS_BODY  = 2'd1,
    RXS_DRAIN = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pf_tx_build.sv
module pf_tx_build #(
  parameter int PAY_BYTES = pf_pkg::PAY_BYTES,
  parameter int CRC_BYTES = pf_pkg::CRC_BYTES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             src_addr,
  input  logic                   word_start,
  input  logic [PAY_BYTES*8-1:0] word,
  input  logic [7:0]             dst_addr,
  output logic                   word_ready,
  output logic                   byte_start,
  output logic [7:0]             byte_data,
  input  logic                   byte_ready
);
  localparam int BODY_LEN   = 2 + PAY_BYTES + CRC_BYTES;
  localparam int TOTAL      = BODY_LEN + 1;
  localparam int FRAME_BITS = TOTAL * 8;
  localparam int CNT_W      = $clog2(TOTAL);
  localparam logic [7:0]       LEN_BYTE = 8'(BODY_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);

  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  take_word, take_byte;

  assign take_word  = word_start && !busy_q;
  assign take_byte  = busy_q && byte_ready;
  assign word_ready = !busy_q;
  assign byte_start = busy_q;
  assign byte_data  = frame_q[FRAME_BITS-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (take_word) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      frame_q <= {LEN_BYTE, dst_addr, src_addr, word, {(CRC_BYTES*8){1'b0}}};
    end else if (take_byte) begin
      frame_q <= frame_q << 8;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    byte_start && !byte_ready |=> byte_start && $stable(byte_data)); // R3
  AST_TX_LEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_start) |-> byte_data == LEN_BYTE); // R2
  AST_TX_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst)
    byte_start && !(byte_ready && cnt_q == CNT_LAST) |=> !word_ready); // R1
endmodule

// File: rtl/pf_rx_filter.sv
module pf_rx_filter #(
  parameter int PAY_BYTES = pf_pkg::PAY_BYTES,
  parameter int CRC_BYTES = pf_pkg::CRC_BYTES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             addr_a,
  input  logic [7:0]             addr_b,
  input  logic                   byte_start,
  input  logic [7:0]             byte_data,
  output logic                   byte_ready,
  output logic                   word_start,
  output logic [PAY_BYTES*8-1:0] word,
  output logic [7:0]             src,
  input  logic                   word_ready
);
  import pf_pkg::*;
  localparam int BODY_LEN = 2 + PAY_BYTES + CRC_BYTES;
  localparam int POS_W    = $clog2(BODY_LEN);
  localparam logic [7:0]       LEN_BYTE = 8'(BODY_LEN);
  localparam logic [POS_W-1:0] POS_DST  = POS_W'(0);
  localparam logic [POS_W-1:0] POS_SRC  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_PAY0 = POS_W'(2);
  localparam logic [POS_W-1:0] POS_PAYE = POS_W'(2 + PAY_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BODY_LEN - 1);

  rx_state_e             st_q;
  logic [POS_W-1:0]      pos_q;
  logic [7:0]            left_q;
  logic [7:0]            dst_q, src_q;
  logic [PAY_BYTES*8-1:0] pay_q, word_q;
  logic                  out_q;
  logic                  take, dst_hit;

  assign byte_ready = !out_q;
  assign take       = byte_start && !out_q;
  assign dst_hit    = (dst_q != ADDR_NONE) &&
                      (dst_q == addr_a || dst_q == addr_b || dst_q == ADDR_BCAST);
  assign word_start = out_q;
  assign word       = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RXS_LEN;
      pos_q  <= '0;
      left_q <= '0;
      dst_q  <= '0;
      src_q  <= '0;
      pay_q  <= '0;
      word_q <= '0;
      src    <= '0;
      out_q  <= 1'b0;
    end else begin
      if (out_q && word_ready) out_q <= 1'b0;
      if (take) begin
        unique case (st_q)
          RXS_LEN: begin
            pos_q <= '0;
            if (byte_data == LEN_BYTE) st_q <= RXS_BODY;
            else if (byte_data != 8'h00) begin
              st_q   <= RXS_DRAIN;
              left_q <= byte_data;
            end
          end
          RXS_BODY: begin
            pos_q <= pos_q + 1'b1;
            if (pos_q == POS_DST) dst_q <= byte_data;
            if (pos_q == POS_SRC) src_q <= byte_data;
            if (pos_q >= POS_PAY0 && pos_q < POS_PAYE)
              pay_q <= {pay_q[PAY_BYTES*8-9:0], byte_data};
            if (pos_q == POS_LAST) begin
              st_q <= RXS_LEN;
              if (dst_hit) begin
                out_q  <= 1'b1;
                word_q <= pay_q;
                src    <= src_q;
              end
            end
          end
          RXS_DRAIN: begin
            left_q <= left_q - 1'b1;
            if (left_q == 8'd1) st_q <= RXS_LEN;
          end
          default: st_q <= RXS_LEN;
        endcase
      end
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    word_start && !word_ready |=> word_start && $stable(word) && $stable(src)); // R8
  AST_RX_NO_ZERO_DST: assert property (@(posedge clk) disable iff (rst)
    $rose(word_start) |-> dst_q != ADDR_NONE); // R6
  AST_RX_DRAIN_EXIT: assert property (@(posedge clk) disable iff (rst)
    st_q == RXS_DRAIN && take && left_q == 8'd1 |=> st_q == RXS_LEN); // R7
endmodule

// File: rtl/pf_chan_ctl.sv
module pf_chan_ctl #(
  parameter int CH_W = pf_pkg::CH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_start,
  input  logic [CH_W-1:0] req_val,
  input  logic            ack,
  output logic [CH_W-1:0] chan,
  output logic            pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan    <= '0;
      pending <= 1'b0;
    end else if (req_start) begin
      chan    <= req_val;
      pending <= 1'b1;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end

  AST_CH_LOAD: assert property (@(posedge clk) disable iff (rst)
    req_start |=> pending && chan == $past(req_val)); // R9
  AST_CH_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_start && !ack |=> $stable(pending) && $stable(chan)); // R9
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int PAY_BYTES = pf_pkg::PAY_BYTES,
  parameter int CRC_BYTES = pf_pkg::CRC_BYTES,
  parameter int CH_W      = pf_pkg::CH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             addr_a,
  input  logic [7:0]             addr_b,
  input  logic                   tx_word_start,
  input  logic [PAY_BYTES*8-1:0] tx_word,
  input  logic [7:0]             tx_dst,
  output logic                   tx_word_ready,
  output logic                   txb_start,
  output logic [7:0]             txb_data,
  input  logic                   txb_ready,
  input  logic                   rxb_start,
  input  logic [7:0]             rxb_data,
  output logic                   rxb_ready,
  output logic                   rx_word_start,
  output logic [PAY_BYTES*8-1:0] rx_word,
  output logic [7:0]             rx_src,
  input  logic                   rx_word_ready,
  input  logic                   ch_req_start,
  input  logic [CH_W-1:0]        ch_req_val,
  output logic [CH_W-1:0]        chan,
  output logic                   ch_pending,
  input  logic                   ch_ack
);
  pf_tx_build #(.PAY_BYTES(PAY_BYTES), .CRC_BYTES(CRC_BYTES)) u_tx (
    .clk(clk), .rst(rst), .src_addr(addr_a),
    .word_start(tx_word_start), .word(tx_word), .dst_addr(tx_dst),
    .word_ready(tx_word_ready), .byte_start(txb_start),
    .byte_data(txb_data), .byte_ready(txb_ready)
  );

  pf_rx_filter #(.PAY_BYTES(PAY_BYTES), .CRC_BYTES(CRC_BYTES)) u_rx (
    .clk(clk), .rst(rst), .addr_a(addr_a), .addr_b(addr_b),
    .byte_start(rxb_start), .byte_data(rxb_data), .byte_ready(rxb_ready),
    .word_start(rx_word_start), .word(rx_word), .src(rx_src),
    .word_ready(rx_word_ready)
  );

  pf_chan_ctl #(.CH_W(CH_W)) u_ch (
    .clk(clk), .rst(rst), .req_start(ch_req_start), .req_val(ch_req_val),
    .ack(ch_ack), .chan(chan), .pending(ch_pending)
  );
endmodule

// File: tb/test_pkt_framer.sv
`timescale 1ns/1ps
module test_pkt_framer;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  addr_a, addr_b;
  logic        tx_word_start;
  logic [31:0] tx_word;
  logic [7:0]  tx_dst;
  logic        tx_word_ready, txb_start, txb_ready;
  logic [7:0]  txb_data;
  logic        rxb_start, rxb_ready;
  logic [7:0]  rxb_data;
  logic        rx_word_start, rx_word_ready;
  logic [31:0] rx_word;
  logic [7:0]  rx_src;
  logic        ch_req_start, ch_pending, ch_ack;
  logic [3:0]  ch_req_val, chan;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pkt_framer i_pkt_framer (
    .clk(clk), .rst(rst), .addr_a(addr_a), .addr_b(addr_b),
    .tx_word_start(tx_word_start), .tx_word(tx_word), .tx_dst(tx_dst),
    .tx_word_ready(tx_word_ready), .txb_start(txb_start), .txb_data(txb_data),
    .txb_ready(txb_ready), .rxb_start(rxb_start), .rxb_data(rxb_data),
    .rxb_ready(rxb_ready), .rx_word_start(rx_word_start), .rx_word(rx_word),
    .rx_src(rx_src), .rx_word_ready(rx_word_ready), .ch_req_start(ch_req_start),
    .ch_req_val(ch_req_val), .chan(chan), .ch_pending(ch_pending), .ch_ack(ch_ack)
  );

  // {dst, payload}
  localparam logic [39:0] TX_VEC [0:3] = '{
    40'h5A_DEADBEEF, 40'hFF_01234567, 40'h07_80000001, 40'h21_00FF00FF };
  // {expect_accept, dst, src, payload}
  localparam logic [55:0] RX_VEC [0:5] = '{
    56'h01_21_33_01020304, 56'h01_5C_44_A5A55A5A, 56'h01_FF_70_CAFEF00D,
    56'h00_00_12_11111111, 56'h00_22_12_22222222, 56'h00_FE_13_33333333 };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rxb_data  = b;
    rxb_start = 1'b1;
    while (!rxb_ready) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] dst, input logic [7:0] src,
                          input logic [31:0] pay);
    rx_put(8'd8); rx_put(dst); rx_put(src);
    for (int k = 3; k >= 0; k--) rx_put(pay[k*8 +: 8]);
    rx_put(8'h00); rx_put(8'h00);
    @(negedge clk);
    rxb_start = 1'b0;
  endtask

  task automatic rx_release;
    rx_word_ready = 1'b1;
    @(negedge clk);
    rx_word_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] exp_b [0:8];
    rst = 1'b1; addr_a = 8'h21; addr_b = 8'h5C;
    tx_word_start = 0; tx_word = 0; tx_dst = 0; txb_ready = 1'b1;
    rxb_start = 0; rxb_data = 0; rx_word_ready = 0;
    ch_req_start = 0; ch_req_val = 0; ch_ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(chan == 0 && !ch_pending, "R10", {chan, 3'b0, ch_pending}, 0);
    chk(!txb_start && !rx_word_start && rxb_ready, "R10",
        {txb_start, rx_word_start, rxb_ready}, 3'b001);
    chk(tx_word_ready, "R1", tx_word_ready, 1);

    // transmit table
    for (int v = 0; v < 4; v++) begin
      exp_b[0] = 8'd8; exp_b[1] = TX_VEC[v][39:32]; exp_b[2] = addr_a;
      for (int k = 0; k < 4; k++) exp_b[3+k] = TX_VEC[v][31-8*k -: 8];
      exp_b[7] = 8'h00; exp_b[8] = 8'h00;
      chk(tx_word_ready, "R1", tx_word_ready, 1);
      tx_word = TX_VEC[v][31:0]; tx_dst = TX_VEC[v][39:32]; tx_word_start = 1'b1;
      @(negedge clk);
      tx_word_start = 1'b0;
      chk(!tx_word_ready, "R1", tx_word_ready, 0);
      for (int i = 0; i < 9; i++) begin
        if (v == 1 && i == 3) begin
          txb_ready = 1'b0;
          @(negedge clk);
          chk(txb_start && txb_data == exp_b[3], "R3", txb_data, exp_b[3]);
          @(negedge clk);
          chk(txb_start && txb_data == exp_b[3], "R3", txb_data, exp_b[3]);
          txb_ready = 1'b1;
        end
        if (v == 2 && i == 4) begin
          tx_word = 32'h0BAD0BAD; tx_dst = 8'h99; tx_word_start = 1'b1;
        end
        if (v == 2 && i == 5) tx_word_start = 1'b0;
        chk(txb_start && txb_data == exp_b[i], "R2", txb_data, exp_b[i]);
        @(negedge clk);
      end
      chk(!txb_start && tx_word_ready, "R1", {txb_start, tx_word_ready}, 2'b01);
    end

    // receive table
    for (int v = 0; v < 6; v++) begin
      string req;
      req = RX_VEC[v][48] ? ((RX_VEC[v][47:40] == 8'hFF) ? "R5" : "R4") : "R6";
      rx_frame(RX_VEC[v][47:40], RX_VEC[v][39:32], RX_VEC[v][31:0]);
      chk(rx_word_start == RX_VEC[v][48], req, rx_word_start, RX_VEC[v][48]);
      if (RX_VEC[v][48]) begin
        chk(rx_word == RX_VEC[v][31:0] && rx_src == RX_VEC[v][39:32], req,
            {rx_src, rx_word}, RX_VEC[v][39:0]);
        @(negedge clk);
        chk(rx_word_start && rx_word == RX_VEC[v][31:0] && !rxb_ready, "R8",
            {rxb_ready, rx_word}, {1'b0, RX_VEC[v][31:0]});
        rx_release;
        chk(!rx_word_start && rxb_ready, "R8", rx_word_start, 0);
      end else begin
        chk(rxb_ready, "R6", rxb_ready, 1);
      end
    end

    // R7 drain of a foreign-length frame, then zero length, then good frame
    rx_put(8'd3); rx_put(8'd8); rx_put(8'hFF); rx_put(8'h01);
    rx_put(8'd0);
    rx_frame(8'h5C, 8'h66, 32'h13572468);
    chk(rx_word_start && rx_word == 32'h13572468 && rx_src == 8'h66, "R7",
        {rx_src, rx_word}, {8'h66, 32'h13572468});
    rx_release;
    // R7 long foreign frame containing a fake good header
    rx_put(8'd12);
    rx_put(8'd8); rx_put(8'h21); rx_put(8'h01);
    for (int k = 0; k < 9; k++) rx_put(8'hA0 + 8'(k));
    @(negedge clk);
    rxb_start = 1'b0;
    chk(!rx_word_start && rxb_ready, "R7", rx_word_start, 0);

    // R9 channel
    ch_req_val = 4'd9; ch_req_start = 1'b1;
    @(negedge clk);
    ch_req_start = 1'b0;
    chk(chan == 4'd9 && ch_pending, "R9", {chan, 3'b0, ch_pending}, 8'h91);
    @(negedge clk);
    chk(ch_pending, "R9", ch_pending, 1);
    ch_ack = 1'b1;
    @(negedge clk);
    ch_ack = 1'b0;
    chk(!ch_pending && chan == 4'd9, "R9", {chan, 3'b0, ch_pending}, 8'h90);
    ch_req_val = 4'd3; ch_req_start = 1'b1; ch_ack = 1'b1;
    @(negedge clk);
    ch_req_start = 1'b0; ch_ack = 1'b0;
    chk(ch_pending && chan == 4'd3, "R9", {chan, 3'b0, ch_pending}, 8'h31);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule